// File: doc/BRIEF.md
# H-Bridge Gate Sequencer

This block turns a logic-level pulse-width-modulated signal and a direction bit into the four gate enables of a full H-bridge. The two half-bridge legs are called A (left) and B (right). Each leg has a high-side switch and a low-side switch. Forward drive conducts through the high switch of leg A and the low switch of leg B. Reverse drive conducts through the high switch of leg B and the low switch of leg A. The active diagonal pair is switched on and off by the modulating input, so the duty cycle at the gates follows the duty cycle at the input.

Both inputs are asynchronous to the clock. They pass through the same synchronizer, so they stay aligned with each other. The direction decision is made by a small state machine with four states: idle, forward, dead and reverse. Every change of direction passes through a dead interval of a parameterised number of clocks. During that interval all four gates are off, and the new direction is read only when the interval ends. The gate enables come straight from flip-flops, so they cannot glitch. The analog gate drivers and power transistors are outside the block.

Top module: `hb_seq`

## Requirements
- R1: While `rst_ni` is low, all four gate outputs are 0. After reset is released, the block stays idle with all gates 0 until the synchronizer holds valid data. With defaults (SYNC_STAGES=2), the first enabled pair appears on the third rising edge after release.
- R2: With the direction input at 1 (forward) and modulation at 1, the gate vector `{hi_a, lo_a, hi_b, lo_b}` settles to 4'b1001, so only the leg-A high and leg-B low switches are on.
- R3: With the direction input at 0 (reverse) and modulation at 1, the gate vector settles to 4'b0110, so only the leg-B high and leg-A low switches are on.
- R4: With modulation at 0, all four gates are 0 in either direction. A change on `pwm_i` reaches the gates on the (SYNC_STAGES+1)th rising edge after it is applied, which is the third edge with defaults.
- R5: The high and low switches of one leg are never on in the same cycle. This holds for leg A and for leg B.
- R6: On a direction change, the old pair turns off and all gates stay 0 for exactly DEAD_CYCLES clocks (default 4). The new pair then turns on, gated by modulation.
- R7: If the direction input returns to its old value before the dead interval ends, the opposite pair is never enabled. After the dead interval the original pair resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | Modulating signal, asynchronous |
| fwd_i | input | 1 | Direction: 1 forward, 0 reverse, asynchronous |
| hi_a_o | output | 1 | Gate enable, leg A high-side switch |
| lo_a_o | output | 1 | Gate enable, leg A low-side switch |
| hi_b_o | output | 1 | Gate enable, leg B high-side switch |
| lo_b_o | output | 1 | Gate enable, leg B low-side switch |

## Verification
The checker proves on every cycle the properties that guard the transistors. Neither leg ever conducts on both switches at once. A pair never turns on unless the synchronized modulation was high one cycle earlier. Each diagonal pair appears only when the synchronized direction agrees with it. A reversal is always preceded by at least DEAD_CYCLES all-off cycles, measured by a counter in the checker. Other behaviour can only be shown by the bench scenarios: the exact latency, the exact dead interval, the release from reset, and the aborted reversal that falls back to the original pair.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_DEAD = 2'd2,
        ST_REV  = 2'd3
    } hb_state_e;

    typedef struct packed {
        logic hi_a;
        logic lo_a;
        logic hi_b;
        logic lo_b;
    } hb_gates_t;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] q;
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) q <= '0;
                else         q <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) q <= '0;
                else         q <= g_stage[g-1].q;
            end
        end
    end

    assign q_o = g_stage[STAGES-1].q;

endmodule

// File: rtl/hb_fsm.sv
module hb_fsm
    import hb_seq_pkg::*;
#(
    parameter int DEAD_CYCLES = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      fwd_s_i,
    output hb_state_e state_d_o
);

    localparam int MAX_CNT = (DEAD_CYCLES > SYNC_STAGES) ? DEAD_CYCLES : SYNC_STAGES;
    localparam int CW      = $clog2(MAX_CNT + 1);

    typedef struct packed {
        hb_state_e     state;
        logic [CW-1:0] cnt;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    // Next-state: idle waits for the synchronizer to fill, dead waits out
    // the lockout interval, both then pick the direction seen at that time.
    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE, ST_DEAD: begin
                if (r_q.cnt == '0) begin
                    r_d.state = fwd_s_i ? ST_FWD : ST_REV;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_FWD: begin
                if (!fwd_s_i) begin
                    r_d.state = ST_DEAD;
                    r_d.cnt   = CW'(DEAD_CYCLES - 1);
                end
            end
            ST_REV: begin
                if (fwd_s_i) begin
                    r_d.state = ST_DEAD;
                    r_d.cnt   = CW'(DEAD_CYCLES - 1);
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state <= ST_IDLE;
            r_q.cnt   <= CW'(SYNC_STAGES);
        end else begin
            r_q <= r_d;
        end
    end

    assign state_d_o = r_d.state;

endmodule

// File: rtl/hb_gate_map.sv
module hb_gate_map
    import hb_seq_pkg::*;
(
    input  hb_state_e state_i,
    input  logic      pwm_i,
    output hb_gates_t gates_o
);

    always_comb begin
        gates_o = '0;
        if (pwm_i) begin
            unique case (state_i)
                ST_FWD: begin
                    gates_o.hi_a = 1'b1;
                    gates_o.lo_b = 1'b1;
                end
                ST_REV: begin
                    gates_o.hi_b = 1'b1;
                    gates_o.lo_a = 1'b1;
                end
                default: gates_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/hb_seq.sv
module hb_seq
    import hb_seq_pkg::*;
#(
    parameter int DEAD_CYCLES = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pwm_i,
    input  logic fwd_i,
    output logic hi_a_o,
    output logic lo_a_o,
    output logic hi_b_o,
    output logic lo_b_o
);

    logic      pwm_s;
    logic      fwd_s;
    hb_state_e state_d;
    hb_gates_t gates_d, gates_q;

    hb_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({pwm_i, fwd_i}),
        .q_o    ({pwm_s, fwd_s})
    );

    hb_fsm #(
        .DEAD_CYCLES (DEAD_CYCLES),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fwd_s_i   (fwd_s),
        .state_d_o (state_d)
    );

    hb_gate_map u_map (
        .state_i (state_d),
        .pwm_i   (pwm_s),
        .gates_o (gates_d)
    );

    // Gate enables leave from flops so they never glitch.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gates_q <= '0;
        else         gates_q <= gates_d;
    end

    assign hi_a_o = gates_q.hi_a;
    assign lo_a_o = gates_q.lo_a;
    assign hi_b_o = gates_q.hi_b;
    assign lo_b_o = gates_q.lo_b;

endmodule

// File: rtl/hb_seq_chk.sv
module hb_seq_chk #(
    parameter int DEAD_CYCLES = 4
) (
    input logic clk_i,
    input logic rst_ni,
    input logic hi_a_i,
    input logic lo_a_i,
    input logic hi_b_i,
    input logic lo_b_i,
    input logic pwm_s_i,
    input logic fwd_s_i
);

    localparam int ZW = $clog2(DEAD_CYCLES + 2);
    localparam logic [ZW-1:0] ZMAX = ZW'(DEAD_CYCLES + 1);

    logic [ZW-1:0] zero_run_q;
    logic [1:0]    last_side_q;   // 0 none, 1 forward, 2 reverse
    logic          any_on;
    logic          fwd_on;
    logic          rev_on;

    assign fwd_on = hi_a_i || lo_b_i;
    assign rev_on = hi_b_i || lo_a_i;
    assign any_on = fwd_on || rev_on;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            zero_run_q  <= '0;
            last_side_q <= 2'd0;
        end else begin
            if (any_on)                 zero_run_q <= '0;
            else if (zero_run_q != ZMAX) zero_run_q <= zero_run_q + 1'b1;
            if (fwd_on)      last_side_q <= 2'd1;
            else if (rev_on) last_side_q <= 2'd2;
        end
    end

    p_leg_a_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hi_a_i && lo_a_i));

    p_leg_b_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hi_b_i && lo_b_i));

    p_pwm_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_on |-> $past(pwm_s_i));

    p_fwd_needs_dir_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fwd_on |-> $past(fwd_s_i));

    p_rev_needs_dir_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rev_on |-> !$past(fwd_s_i));

    p_dead_to_rev_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rev_on && last_side_q == 2'd1) |-> (zero_run_q >= ZW'(DEAD_CYCLES)));

    p_dead_to_fwd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fwd_on && last_side_q == 2'd2) |-> (zero_run_q >= ZW'(DEAD_CYCLES)));

endmodule

bind hb_seq hb_seq_chk #(
    .DEAD_CYCLES (DEAD_CYCLES)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hi_a_i  (hi_a_o),
    .lo_a_i  (lo_a_o),
    .hi_b_i  (hi_b_o),
    .lo_b_i  (lo_b_o),
    .pwm_s_i (pwm_s),
    .fwd_s_i (fwd_s)
);

// File: tb/test_hb_seq.sv
module test_hb_seq;

    localparam int DEAD = 4;
    localparam int LAT  = 3;           // SYNC_STAGES + 1 edges
    localparam int SETTLE = 12;

    // {pwm, fwd, expected {hi_a,lo_a,hi_b,lo_b}}
    localparam logic [5:0] VECS [8] = '{
        6'b11_1001, 6'b01_0000, 6'b11_1001, 6'b10_0110,
        6'b00_0000, 6'b10_0110, 6'b01_0000, 6'b11_1001
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm = 1'b0;
    logic fwd = 1'b0;
    logic hi_a, lo_a, hi_b, lo_b;
    int   compared = 0;
    int   mismatched = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    hb_seq #(.DEAD_CYCLES(DEAD), .SYNC_STAGES(2)) i_hb_seq (
        .clk_i (clk), .rst_ni (rst_n), .pwm_i (pwm), .fwd_i (fwd),
        .hi_a_o (hi_a), .lo_a_o (lo_a), .hi_b_o (hi_b), .lo_b_o (lo_b)
    );

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] got;
        got = {hi_a, lo_a, hi_b, lo_b};
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // R5: leg exclusivity observed on every cycle out of reset
    always @(negedge clk) begin
        if (rst_n && !done) begin
            compared++;
            if ((hi_a && lo_a) || (hi_b && lo_b)) begin
                mismatched++;
                $display("FAIL R5: got %b expected no leg overlap", {hi_a, lo_a, hi_b, lo_b});
            end
        end
    end

    task automatic do_reset(input logic p, input logic f);
        @(negedge clk);
        rst_n = 1'b0; pwm = p; fwd = f;
        repeat (3) @(negedge clk);
        check("R1 during reset", 4'b0000);
        rst_n = 1'b1;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset and release timing
        do_reset(1'b1, 1'b1);
        @(negedge clk); check("R1 idle edge 1", 4'b0000);
        @(negedge clk); check("R1 idle edge 2", 4'b0000);
        @(negedge clk); check("R1 first drive", 4'b1001);

        // Table walk: R2, R3, R4 steady states
        for (int i = 0; i < 8; i++) begin
            pwm = VECS[i][5];
            fwd = VECS[i][4];
            repeat (SETTLE) @(negedge clk);
            check(VECS[i][4] ? "R2/R4 table" : "R3/R4 table", VECS[i][3:0]);
        end

        // R6: exact dead interval forward -> reverse
        pwm = 1'b1; fwd = 1'b1;
        repeat (SETTLE) @(negedge clk);
        fwd = 1'b0;
        for (int k = 1; k <= LAT + DEAD; k++) begin
            @(negedge clk);
            if (k < LAT)             check("R6 old pair holds", 4'b1001);
            else if (k < LAT + DEAD) check("R6 dead all off", 4'b0000);
            else                     check("R6 new pair", 4'b0110);
        end

        // R6: reverse -> forward
        repeat (SETTLE) @(negedge clk);
        fwd = 1'b1;
        for (int k = 1; k <= LAT + DEAD; k++) begin
            @(negedge clk);
            if (k < LAT)             check("R6 rev holds", 4'b0110);
            else if (k < LAT + DEAD) check("R6 dead all off", 4'b0000);
            else                     check("R6 fwd pair", 4'b1001);
        end

        // R7: one-cycle direction glitch during forward
        repeat (SETTLE) @(negedge clk);
        fwd = 1'b0;
        @(negedge clk);
        check("R7 before glitch seen", 4'b1001);
        fwd = 1'b1;
        for (int k = 2; k <= LAT + DEAD + 2; k++) begin
            @(negedge clk);
            if (k < LAT)             check("R7 holds", 4'b1001);
            else if (k < LAT + DEAD) check("R7 dead all off", 4'b0000);
            else                     check("R7 original pair back", 4'b1001);
        end

        // R4: modulation follows with fixed latency in reverse
        fwd = 1'b0;
        repeat (SETTLE) @(negedge clk);
        begin
            logic [11:0] pat;
            pat = 12'b1011_0010_1101;
            for (int k = 0; k < 12 + LAT; k++) begin
                if (k >= LAT)
                    check("R4 duty follow", pat[k-LAT] ? 4'b0110 : 4'b0000);
                if (k < 12) pwm = pat[k];
                @(negedge clk);
            end
        end

        // R1: reset mid-drive clears outputs, then resumes reverse
        do_reset(1'b1, 1'b0);
        @(negedge clk); check("R1 idle after reset", 4'b0000);
        @(negedge clk); check("R1 idle after reset", 4'b0000);
        @(negedge clk); check("R1/R3 resume reverse", 4'b0110);

        finish_run();
    end

endmodule